// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Engine

This block encrypts a single 128-bit plaintext under a 128-bit key with the AES-128 cipher, using a 32-bit datapath. The caller asserts `start` for one cycle and presents the first plaintext word and the first key word in that same cycle. The remaining three word pairs follow in the next three cycles. The engine then runs ten rounds of five cycles each. It pulses `done` for one cycle when the ciphertext register has been updated.

The engine has only four byte substitution units. In each round, four cycles stream one state column at a time through them. The fifth cycle lends them to the key schedule, which builds the next round key in that one cycle. The previous round's state sits shifted in a hold register. Each column is taken from it, passed through a combinational column mix, and XORed with its round key word just before substitution. The last round skips the mix and adds the final round key directly into the output register.

Top module: `aes_ws_core`

## Requirements
- R1: The cycle that accepts `start` carries word 0 (bits 127:96) of both plaintext and key. Words 1, 2 and 3 are taken in the three cycles that follow, whatever `start` does in those cycles.
- R2: `cipher_out` equals the AES-128 encryption of the loaded plaintext under the loaded key. Byte 0 of the block sits in bits 127:120.
- R3: `done` is high right after the 54th rising edge, counting the edge that accepts `start` as the first.
- R4: `done` stays high for exactly one cycle.
- R5: `cipher_out` changes only on the edge that raises `done`. It holds its value while idle, whatever values `data_in` and `key_in` carry, and also while the next block is loading and running.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`, where it falls.
- R7: A `start` that arrives while `busy` is high is ignored. The running block finishes with the same latency and the same result.
- R8: A `start` given in the cycle in which `done` is high is accepted, so blocks can run back to back.
- R9: After reset, `busy` and `done` are low and `cipher_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; accepted only while not busy |
| data_in | input | 32 | Plaintext word for the current load cycle |
| key_in | input | 32 | Key word for the current load cycle |
| busy | output | 1 | A block is loading or running |
| done | output | 1 | One-cycle pulse: new ciphertext available |
| cipher_out | output | 128 | Ciphertext of the last finished block |

## Verification
A wrong phase or round count inside the controller shows up at the ports as `done` rising earlier or later than the 54th edge. It therefore appears at the end of the very first block. A wrong byte anywhere in the state, the key register or the round constant spreads through the remaining rounds. It shows as a ciphertext mismatch at the next `done`, usually in almost every bit. Random blocks are checked against a reference model in the bench, directed blocks against published constants. Ignored starts and back-to-back starts probe the controller's idle window, which is the only place a start can be missed or taken twice.

// File: rtl/aes_ws_pkg.sv
package aes_ws_pkg;

   typedef logic [7:0] gf_byte_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RUN
   } ctl_state_e;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic gf_byte_t gf_x2(input gf_byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   // general product in GF(2^8), shift-and-add form
   function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
      gf_byte_t acc;
      gf_byte_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_x2(sh);
      end
      return acc;
   endfunction

endpackage

// File: rtl/aes_ws_sbox.sv
module aes_ws_sbox
   import aes_ws_pkg::*;
(
   input  logic [7:0] in_i,
   output logic [7:0] out_o
);
   gf_byte_t p2, p3, p6, p12, p15, p30, p60, p120, p240, inv;
   gf_byte_t aff;

   // multiplicative inverse as in_i^254 (zero maps to zero)
   always_comb begin
      p2   = gf_mul(in_i, in_i);
      p3   = gf_mul(p2, in_i);
      p6   = gf_mul(p3, p3);
      p12  = gf_mul(p6, p6);
      p15  = gf_mul(p12, p3);
      p30  = gf_mul(p15, p15);
      p60  = gf_mul(p30, p30);
      p120 = gf_mul(p60, p60);
      p240 = gf_mul(p120, p120);
      inv  = gf_mul(gf_mul(p240, p12), p2);
   end

   // affine step: sum of four left rotations plus constant
   always_comb begin
      aff = inv
          ^ {inv[6:0], inv[7]}
          ^ {inv[5:0], inv[7:6]}
          ^ {inv[4:0], inv[7:5]}
          ^ {inv[3:0], inv[7:4]}
          ^ 8'h63;
   end

   assign out_o = aff;
endmodule

// File: rtl/aes_ws_mixcol.sv
module aes_ws_mixcol
   import aes_ws_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] col_i,
   output logic [WORD_W-1:0] col_o
);
   localparam int BPW = WORD_W / 8;

   gf_byte_t a [BPW];
   gf_byte_t d [BPW];

   for (genvar r = 0; r < BPW; r++) begin : g_row
      assign a[r] = col_i[(BPW-1-r)*8 +: 8];
      assign d[r] = gf_x2(a[r]);
   end

   // each output row: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
   for (genvar r = 0; r < BPW; r++) begin : g_out
      assign col_o[(BPW-1-r)*8 +: 8] = d[r]
                                     ^ d[(r+1)%BPW] ^ a[(r+1)%BPW]
                                     ^ a[(r+2)%BPW]
                                     ^ a[(r+3)%BPW];
   end
endmodule

// File: rtl/aes_ws_keystep.sv
module aes_ws_keystep
#(
   parameter int WORD_W = 32,
   parameter int WORDS  = 4
) (
   input  logic [WORDS-1:0][WORD_W-1:0] key_i,
   input  logic [WORD_W-1:0]            subrot_i,
   input  logic [7:0]                   rcon_i,
   output logic [WORDS-1:0][WORD_W-1:0] key_o
);
   logic [WORD_W-1:0] head;

   assign head     = subrot_i ^ {rcon_i, {(WORD_W-8){1'b0}}};
   assign key_o[0] = key_i[0] ^ head;

   for (genvar i = 1; i < WORDS; i++) begin : g_chain
      assign key_o[i] = key_i[i] ^ key_o[i-1];
   end
endmodule

// File: rtl/aes_ws_ctrl.sv
module aes_ws_ctrl
   import aes_ws_pkg::*;
#(
   parameter  int WORDS  = 4,
   parameter  int ROUNDS = 10,
   localparam int IDX_W  = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             accept,
   output logic             load_we,
   output logic [IDX_W-1:0] load_idx,
   output logic             col_en,
   output logic [IDX_W-1:0] col_idx,
   output logic             key_step,
   output logic             first_rnd,
   output logic             last_rnd
);
   localparam int PH_W = $clog2(WORDS + 1);
   localparam int RN_W = $clog2(ROUNDS + 1);
   localparam logic [PH_W-1:0] PH_KEY       = PH_W'(WORDS);
   localparam logic [PH_W-1:0] PH_LAST_LOAD = PH_W'(WORDS - 1);
   localparam logic [PH_W-1:0] PH_ONE       = PH_W'(1);
   localparam logic [RN_W-1:0] RN_FIRST     = RN_W'(1);
   localparam logic [RN_W-1:0] RN_LAST      = RN_W'(ROUNDS);

   ctl_state_e      st_q;
   logic [PH_W-1:0] ph_q;
   logic [RN_W-1:0] rn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ph_q <= '0;
         rn_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q <= ST_LOAD;
                  ph_q <= PH_ONE;
               end
            end
            ST_LOAD: begin
               if (ph_q == PH_LAST_LOAD) begin
                  st_q <= ST_RUN;
                  ph_q <= '0;
                  rn_q <= RN_FIRST;
               end else begin
                  ph_q <= ph_q + PH_ONE;
               end
            end
            ST_RUN: begin
               if (ph_q == PH_KEY) begin
                  ph_q <= '0;
                  if (rn_q == RN_LAST) st_q <= ST_IDLE;
                  else                 rn_q <= rn_q + RN_FIRST;
               end else begin
                  ph_q <= ph_q + PH_ONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign accept    = (st_q == ST_IDLE) && start;
   assign load_we   = accept || (st_q == ST_LOAD);
   assign load_idx  = accept ? '0 : ph_q[IDX_W-1:0];
   assign col_en    = (st_q == ST_RUN) && (ph_q != PH_KEY);
   assign col_idx   = ph_q[IDX_W-1:0];
   assign key_step  = (st_q == ST_RUN) && (ph_q == PH_KEY);
   assign first_rnd = (rn_q == RN_FIRST);
   assign last_rnd  = (rn_q == RN_LAST);
endmodule

// File: rtl/aes_ws_core.sv
module aes_ws_core
   import aes_ws_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ROUNDS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] data_in,
   input  logic [WORD_W-1:0] key_in,
   output logic              busy,
   output logic              done,
   output logic [127:0]      cipher_out
);
   localparam int BLK_W = 128;
   localparam int WORDS = BLK_W / WORD_W;
   localparam int BPW   = WORD_W / 8;
   localparam int IDX_W = $clog2(WORDS);

   // elaboration-time parameter checks
   if (WORD_W != 32) begin : g_bad_word
      $error("aes_ws_core: WORD_W must be 32 (square 4x4 byte state)");
   end
   if (WORDS != BPW) begin : g_bad_shape
      $error("aes_ws_core: state must have as many columns as rows");
   end
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("aes_ws_core: ROUNDS must be at least 1");
   end

   logic             accept, load_we, col_en, key_step, first_rnd, last_rnd;
   logic [IDX_W-1:0] load_idx, col_idx;

   aes_ws_ctrl #(
      .WORDS  (WORDS),
      .ROUNDS (ROUNDS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy),
      .accept    (accept),
      .load_we   (load_we),
      .load_idx  (load_idx),
      .col_en    (col_en),
      .col_idx   (col_idx),
      .key_step  (key_step),
      .first_rnd (first_rnd),
      .last_rnd  (last_rnd)
   );

   // state: hold = shifted state of previous round (or whitened input)
   logic [WORDS-1:0][WORD_W-1:0] hold_q, sbuf_q, key_q, cipher_q;
   logic [WORDS-1:0][WORD_W-1:0] key_nx, shifted;
   gf_byte_t                     rcon_q;

   logic [WORD_W-1:0] col_src, mc_out, round_col, rot_last, sbox_in, sbox_out;

   assign col_src = hold_q[col_idx];

   aes_ws_mixcol #(.WORD_W(WORD_W)) u_mix (
      .col_i (col_src),
      .col_o (mc_out)
   );

   assign round_col = first_rnd ? col_src : (mc_out ^ key_q[col_idx]);
   assign rot_last  = {key_q[WORDS-1][WORD_W-9:0], key_q[WORDS-1][WORD_W-1 -: 8]};
   assign sbox_in   = key_step ? rot_last : round_col;

   // the single shared bank of byte substitution units
   for (genvar b = 0; b < BPW; b++) begin : g_sbox
      aes_ws_sbox u_sb (
         .in_i  (sbox_in[b*8 +: 8]),
         .out_o (sbox_out[b*8 +: 8])
      );
   end

   aes_ws_keystep #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS)
   ) u_key (
      .key_i    (key_q),
      .subrot_i (sbox_out),
      .rcon_i   (rcon_q),
      .key_o    (key_nx)
   );

   // row r rotates left by r columns
   for (genvar c = 0; c < WORDS; c++) begin : g_sr_col
      for (genvar r = 0; r < BPW; r++) begin : g_sr_row
         assign shifted[c][(BPW-1-r)*8 +: 8] = sbuf_q[(c+r)%WORDS][(BPW-1-r)*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         key_q  <= '0;
         rcon_q <= 8'h01;
      end else if (load_we) begin
         hold_q[load_idx] <= data_in ^ key_in;
         key_q[load_idx]  <= key_in;
         if (accept) rcon_q <= 8'h01;
      end else if (key_step) begin
         hold_q <= shifted;
         key_q  <= key_nx;
         rcon_q <= gf_x2(rcon_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sbuf_q <= '0;
      else if (col_en) sbuf_q[col_idx] <= sbox_out;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cipher_q <= '0;
         done     <= 1'b0;
      end else begin
         done <= key_step && last_rnd;
         if (key_step && last_rnd) cipher_q <= shifted ^ key_nx;
      end
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_out
      assign cipher_out[(WORDS-1-i)*WORD_W +: WORD_W] = cipher_q[i];
   end
endmodule

// File: rtl/aes_ws_core_chk.sv
module aes_ws_core_chk #(
   parameter int WORD_W = 32,
   parameter int ROUNDS = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [127:0] cipher_out
);
   localparam int WORDS = 128 / WORD_W;
   localparam int LAT   = WORDS + (WORDS + 1) * ROUNDS;

   logic [15:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= 16'd1;
      else if (busy)             lat_cnt <= lat_cnt + 16'd1;
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == 16'(LAT)));                                   // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R4

   AST_CIPHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(cipher_out));                                    // R5

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R6

   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                             // R6

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                        // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !$fell(busy)) |=> (busy || done));               // R7
endmodule

bind aes_ws_core aes_ws_core_chk #(
   .WORD_W (WORD_W),
   .ROUNDS (ROUNDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .cipher_out (cipher_out)
);

// File: tb/aes_ws_core_test.sv
module aes_ws_core_test;

   logic         clk;
   logic         rst_n;
   logic         start;
   logic [31:0]  data_in;
   logic [31:0]  key_in;
   logic         busy;
   logic         done;
   logic [127:0] cipher_out;

   int checks = 0;
   int errors = 0;

   logic [7:0] sbt [256];

   aes_ws_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .data_in    (data_in),
      .key_in     (key_in),
      .busy       (busy),
      .done       (done),
      .cipher_out (cipher_out)
   );

   initial clk = 1'b0;
   always #10ns clk = ~clk;

   // ---------------- reference model ----------------
   function automatic logic [7:0] bgm(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   task automatic build_table();
      for (int x = 0; x < 256; x++) begin
         logic [7:0] v, o, c;
         v = 8'h00;
         for (int y = 1; y < 256; y++)
            if (bgm(8'(x), 8'(y)) == 8'h01) v = 8'(y);
         c = 8'h63;
         for (int i = 0; i < 8; i++)
            o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
         sbt[x] = o;
      end
   endtask

   function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
      logic [7:0] s [16];
      logic [7:0] k [16];
      logic [7:0] t [16];
      logic [7:0] m [16];
      logic [7:0] rc;
      logic [127:0] res;
      for (int i = 0; i < 16; i++) begin
         k[i] = key[127-8*i -: 8];
         s[i] = pt[127-8*i -: 8] ^ k[i];
      end
      rc = 8'h01;
      for (int r = 1; r <= 10; r++) begin
         logic [7:0] g0, g1, g2, g3;
         g0 = sbt[k[13]] ^ rc;
         g1 = sbt[k[14]];
         g2 = sbt[k[15]];
         g3 = sbt[k[12]];
         k[0] ^= g0; k[1] ^= g1; k[2] ^= g2; k[3] ^= g3;
         for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
         rc = bgm(rc, 8'h02);
         for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++)
               t[4*c+w] = sbt[s[4*((c+w)%4)+w]];
         if (r < 10) begin
            for (int c = 0; c < 4; c++)
               for (int w = 0; w < 4; w++)
                  m[4*c+w] = bgm(t[4*c+w], 8'h02) ^ bgm(t[4*c+(w+1)%4], 8'h03)
                           ^ t[4*c+(w+2)%4] ^ t[4*c+(w+3)%4];
         end else begin
            for (int i = 0; i < 16; i++) m[i] = t[i];
         end
         for (int i = 0; i < 16; i++) s[i] = m[i] ^ k[i];
      end
      for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
      return res;
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // load and run one block; returns at the negedge where done is seen
   task automatic run_block(input logic [127:0] pt, input logic [127:0] key,
                            input logic [127:0] exp, input bit poke, input bit immediate);
      logic [127:0] prev_ct;
      int  lat;
      bit  busy_ok;
      if (!immediate) @(negedge clk);
      prev_ct = cipher_out;
      start   = 1'b1;
      data_in = pt[127:96];
      key_in  = key[127:96];
      for (int i = 1; i < 4; i++) begin
         @(negedge clk);
         start   = poke;
         data_in = pt[127-32*i -: 32];
         key_in  = key[127-32*i -: 32];
         if (i == 1) begin
            chk(busy == 1'b1, "R6 busy after accept", 128'(busy), 128'd1);
            chk(done == 1'b0, "R4 done one cycle", 128'(done), 128'd0);
            chk(cipher_out == prev_ct, "R5 cipher holds while next block loads", cipher_out, prev_ct);
         end
      end
      @(negedge clk);
      start   = 1'b0;
      data_in = $urandom();
      key_in  = $urandom();
      lat     = 4;
      busy_ok = 1'b1;
      while (!done && lat < 200) begin
         if (!busy) busy_ok = 1'b0;
         if (poke && lat == 17) begin start = 1'b1; data_in = $urandom(); end
         if (poke && lat == 23) start = 1'b0;
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk(lat == 54, poke ? "R7 latency with ignored start" : "R3 latency", 128'(lat), 128'd54);
      chk(busy_ok, "R6 busy through run", 128'(busy_ok), 128'd1);
      chk(busy == 1'b0, "R6 busy low at done", 128'(busy), 128'd0);
      chk(cipher_out == exp, poke ? "R7 result with ignored start" : "R2 ciphertext", cipher_out, exp);
   endtask

   task automatic after_done();
      logic [127:0] held;
      held = cipher_out;
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", 128'(done), 128'd0);
      chk(busy == 1'b0, "R6 idle after done", 128'(busy), 128'd0);
      repeat (3) begin
         data_in = $urandom();
         key_in  = $urandom();
         @(negedge clk);
      end
      chk(cipher_out == held, "R5 cipher holds while idle", cipher_out, held);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   localparam logic [127:0] K_A  = 128'h000102030405060708090a0b0c0d0e0f;
   localparam logic [127:0] P_A  = 128'h00112233445566778899aabbccddeeff;
   localparam logic [127:0] C_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
   localparam logic [127:0] K_B  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] P_B  = 128'h3243f6a8885a308d313198a2e0370734;
   localparam logic [127:0] C_B  = 128'h3925841d02dc09fbdc118597196a0b32;

   initial begin
      logic [127:0] pt, key;
      rst_n   = 1'b0;
      start   = 1'b0;
      data_in = '0;
      key_in  = '0;
      void'($urandom(32'd7031));
      build_table();
      chk(ref_enc(P_A, K_A) == C_A, "R2 reference model sanity", ref_enc(P_A, K_A), C_A);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9 reset busy", 128'(busy), 128'd0);
      chk(done == 1'b0, "R9 reset done", 128'(done), 128'd0);
      chk(cipher_out == '0, "R9 reset cipher", cipher_out, 128'd0);

      // directed: published vectors check R1 word order and R2
      run_block(P_A, K_A, C_A, 1'b0, 1'b0);
      after_done();
      run_block(P_B, K_B, C_B, 1'b0, 1'b0);
      after_done();
      // directed corners: all zeros, all ones
      run_block('0, '0, ref_enc('0, '0), 1'b0, 1'b0);
      after_done();
      run_block('1, '1, ref_enc('1, '1), 1'b1, 1'b0);
      after_done();
      // R8: back-to-back start in the done cycle
      run_block(P_B, K_A, ref_enc(P_B, K_A), 1'b0, 1'b0);
      run_block(P_A, K_B, ref_enc(P_A, K_B), 1'b0, 1'b1);
      after_done();

      // random blocks, some with ignored starts, some back to back
      for (int i = 0; i < 16; i++) begin
         pt  = {$urandom(), $urandom(), $urandom(), $urandom()};
         key = {$urandom(), $urandom(), $urandom(), $urandom()};
         run_block(pt, key, ref_enc(pt, key), (i % 3 == 0), (i % 4 == 1));
         if (i % 4 != 0) after_done();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule